// File: doc/BRIEF.md
# Shift and Rotate Unit

This block shifts or rotates a 32-bit operand for the execute stage of a small processor. Five operations are supported: logical shift left, logical shift right, arithmetic shift right, rotate right and rotate left. The distance comes from one of two places. The first is a 5-bit constant taken from the instruction. The second is an amount held in a register, and only its five least significant bits count.

Every operation runs through one right-shifting logarithmic barrel. The barrel has five stages, moving the data by 1, 2, 4, 8 and 16 positions. A left shift reverses the bit order on the way in and again on the way out. A rotate left by n becomes a rotate right by (32 − n) mod 32.

The result leaves through a single output register. That register has a synchronous active-low reset, so the value for a set of inputs appears one clock after those inputs are presented.

Top module: `shift_rotate_unit`

## Requirements
- R1: Mode code 0, shift left: result bit i equals source bit i−n for i ≥ n, and is 0 otherwise. Bits moved beyond bit 31 are lost.
- R2: Mode code 1, logical shift right: result bit i equals source bit i+n for i+n ≤ 31, and is 0 otherwise.
- R3: Mode code 2, arithmetic shift right: the same as R2, except that the vacated high positions take the value of source bit 31.
- R4: Mode code 3, rotate right: result bit i equals source bit (i+n) mod 32.
- R5: Mode code 4, rotate left: result bit i equals source bit (i−n) mod 32.
- R6: When the amount-select input is 1, n is bits [4:0] of the 32-bit register amount, and bits [31:5] have no effect. When the select input is 0, n is the 5-bit constant amount and the register amount has no effect.
- R7: When n is 0, every valid mode code (0 to 4) returns the source unchanged.
- R8: Every constant amount from 0 to 31 gives the shift or rotate by exactly that many positions.
- R9: The result is registered. The value for inputs present at a rising edge appears after that edge. While the reset input is 0 at a rising edge, the result becomes all zeros.
- R10: Mode codes 5, 6 and 7 give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 32 | Operand to shift or rotate |
| const_amt_i | input | 5 | Shift amount taken from the instruction |
| reg_amt_i | input | 32 | Shift amount supplied by a register; only bits [4:0] are used |
| use_reg_amt_i | input | 1 | 1 selects reg_amt_i, 0 selects const_amt_i |
| mode_i | input | 3 | 0 shift left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate left |
| result_o | output | 32 | Registered result |

## Verification
Amount selection and the rotate-left conversion can act together in one cycle. This happens when the register amount is chosen with bits [4:0] all zero and the upper bits set. The negated amount must then wrap to zero, so rotate left has to return the source unchanged. Arithmetic sign fill and the largest distance also coincide when a negative operand is shifted right by 31. That case must produce all ones, while the same operand under logical right must produce 1. The bench drives these pairings directly and also runs a long pseudo-random sweep. Each cycle it compares the output with a per-bit index model of each mode.

// File: rtl/shf_pkg.sv
// Package: shared mode encoding for the shift and rotate unit.
// Assumes mode codes above SHF_ROL are invalid and produce zero.
package shf_pkg;
    typedef enum logic [2:0] {
        SHF_SLL = 3'd0,
        SHF_SRL = 3'd1,
        SHF_SRA = 3'd2,
        SHF_ROR = 3'd3,
        SHF_ROL = 3'd4
    } shf_mode_e;
endpackage

// File: rtl/shf_amount_sel.sv
// Module: picks the shift distance and turns rotate-left into a right distance.
// Assumes REG_W >= AMT_W; the register bits above AMT_W are dropped on purpose.
module shf_amount_sel #(
    parameter int AMT_W = 5,
    parameter int REG_W = 32
) (
    input  logic [AMT_W-1:0] const_amt_i,
    input  logic [REG_W-1:0] reg_amt_i,
    input  logic             use_reg_i,
    input  logic             to_right_i,
    output logic [AMT_W-1:0] amt_o
);
    logic [AMT_W-1:0] picked;
    logic [AMT_W-1:0] negated;

    // Choose the source of the distance, keeping only its low bits.
    always_comb begin
        picked = use_reg_i ? reg_amt_i[AMT_W-1:0] : const_amt_i;
    end

    // Two's complement negation wraps n to (2^AMT_W - n) mod 2^AMT_W.
    always_comb begin
        negated = '0 - picked;
        amt_o   = to_right_i ? negated : picked;
    end
endmodule

// File: rtl/shf_stage.sv
// Module: one barrel level that moves data right by S positions when enabled.
// Assumes 0 < S < W; the vacated high bits take either the wrapped low bits or the fill bit.
module shf_stage #(
    parameter int W = 32,
    parameter int S = 1
) (
    input  logic [W-1:0] d_i,
    input  logic         en_i,
    input  logic         rot_i,
    input  logic         fill_i,
    output logic [W-1:0] q_o
);
    logic [S-1:0] top_bits;

    // Bits entering at the top: wrapped for rotate, fill bit otherwise.
    always_comb begin
        top_bits = rot_i ? d_i[S-1:0] : {S{fill_i}};
    end

    // Either pass through unchanged or apply this level's displacement.
    always_comb begin
        q_o = en_i ? {top_bits, d_i[W-1:S]} : d_i;
    end
endmodule

// File: rtl/shf_bitrev.sv
// Module: conditional bit-order reversal used to perform left shifts with a right barrel.
// Assumes a purely combinational use; no state.
module shf_bitrev #(
    parameter int W = 32
) (
    input  logic [W-1:0] d_i,
    input  logic         en_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] flipped;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_flip
            assign flipped[g] = d_i[W-1-g];
        end
    endgenerate

    // Select reversed or straight order.
    always_comb begin
        q_o = en_i ? flipped : d_i;
    end
endmodule

// File: rtl/shf_barrel.sv
// Module: logarithmic right barrel with AMT_W levels of 1, 2, 4 ... positions.
// Assumes W == 2**AMT_W so that rotation by any distance is expressible.
module shf_barrel #(
    parameter int W     = 32,
    parameter int AMT_W = 5
) (
    input  logic [W-1:0]     d_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             rot_i,
    input  logic             fill_i,
    output logic [W-1:0]     q_o
);
    logic [W-1:0] lvl [0:AMT_W];

    // Feed the first level.
    always_comb begin
        lvl[0] = d_i;
    end

    genvar k;
    generate
        for (k = 0; k < AMT_W; k++) begin : g_lvl
            shf_stage #(
                .W (W),
                .S (1 << k)
            ) u_stage (
                .d_i    (lvl[k]),
                .en_i   (amt_i[k]),
                .rot_i  (rot_i),
                .fill_i (fill_i),
                .q_o    (lvl[k+1])
            );
        end
    endgenerate

    // Last level is the barrel output.
    always_comb begin
        q_o = lvl[AMT_W];
    end
endmodule

// File: rtl/shift_rotate_unit.sv
// Module: top of the shift and rotate unit; decodes mode, drives the barrel, registers the result.
// Assumes DATA_W is a power of two; result appears one clock after the inputs.
module shift_rotate_unit #(
    parameter int DATA_W = 32,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_i,
    input  logic [$clog2(DATA_W)-1:0] const_amt_i,
    input  logic [REG_W-1:0]  reg_amt_i,
    input  logic              use_reg_amt_i,
    input  logic [2:0]        mode_i,
    output logic [DATA_W-1:0] result_o
);
    import shf_pkg::*;

    localparam int AMT_W = $clog2(DATA_W);

    shf_mode_e         mode;
    logic              valid_mode;
    logic              is_left;
    logic              is_rot;
    logic              is_rol;
    logic              fill_bit;
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] pre;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] post;
    logic [DATA_W-1:0] next_res;
    logic [DATA_W-1:0] result_q;

    // Decode the mode code into barrel controls.
    always_comb begin
        mode       = shf_mode_e'(mode_i);
        valid_mode = (mode_i <= 3'd4);
        is_left    = (mode == SHF_SLL);
        is_rol     = (mode == SHF_ROL);
        is_rot     = (mode == SHF_ROR) || is_rol;
        fill_bit   = (mode == SHF_SRA) && src_i[DATA_W-1];
    end

    shf_amount_sel #(
        .AMT_W (AMT_W),
        .REG_W (REG_W)
    ) u_amt (
        .const_amt_i (const_amt_i),
        .reg_amt_i   (reg_amt_i),
        .use_reg_i   (use_reg_amt_i),
        .to_right_i  (is_rol),
        .amt_o       (amt)
    );

    shf_bitrev #(.W(DATA_W)) u_rev_in (
        .d_i  (src_i),
        .en_i (is_left),
        .q_o  (pre)
    );

    shf_barrel #(
        .W     (DATA_W),
        .AMT_W (AMT_W)
    ) u_barrel (
        .d_i    (pre),
        .amt_i  (amt),
        .rot_i  (is_rot),
        .fill_i (fill_bit),
        .q_o    (shifted)
    );

    shf_bitrev #(.W(DATA_W)) u_rev_out (
        .d_i  (shifted),
        .en_i (is_left),
        .q_o  (post)
    );

    // Force zero for unused mode codes.
    always_comb begin
        next_res = valid_mode ? post : '0;
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else begin
            result_q <= next_res;
        end
    end

    assign result_o = result_q;
endmodule

// File: rtl/shift_rotate_unit_chk.sv
// Checker: temporal properties of the shift and rotate unit, bound to the top.
// Assumes the one-cycle output register of the top module.
module shift_rotate_unit_chk #(
    parameter int DATA_W = 32,
    parameter int REG_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] src_i,
    input logic [$clog2(DATA_W)-1:0] const_amt_i,
    input logic [REG_W-1:0]  reg_amt_i,
    input logic              use_reg_amt_i,
    input logic [2:0]        mode_i,
    input logic [DATA_W-1:0] result_o
);
    localparam int AMT_W = $clog2(DATA_W);

    logic [AMT_W-1:0] eff_amt;

    // Distance as seen at the ports.
    always_comb begin
        eff_amt = use_reg_amt_i ? reg_amt_i[AMT_W-1:0] : const_amt_i;
    end

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0));

    assert_zero_amt_identity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i <= 3'd4 && eff_amt == '0) |=> (result_o == $past(src_i)));

    assert_sll_low_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd0 && eff_amt != '0) |=> (result_o[0] == 1'b0));

    assert_srl_top_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd1 && eff_amt != '0) |=> (result_o[DATA_W-1] == 1'b0));

    assert_sra_top_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd2) |=> (result_o[DATA_W-1] == $past(src_i[DATA_W-1])));

    assert_rotate_keeps_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd3 || mode_i == 3'd4) |=> ($countones(result_o) == $countones($past(src_i))));

    assert_bad_mode_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i > 3'd4) |=> (result_o == '0));
endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(
    .DATA_W (DATA_W),
    .REG_W  (REG_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_i         (src_i),
    .const_amt_i   (const_amt_i),
    .reg_amt_i     (reg_amt_i),
    .use_reg_amt_i (use_reg_amt_i),
    .mode_i        (mode_i),
    .result_o      (result_o)
);

// File: tb/shift_rotate_unit_test.sv
// Bench: drives the unit each cycle and compares with a per-bit index model.
module shift_rotate_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src;
    logic [4:0]  camt;
    logic [31:0] ramt;
    logic        usereg;
    logic [2:0]  mode;
    logic [31:0] res;

    int checks = 0;
    int fails  = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    shift_rotate_unit uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_i         (src),
        .const_amt_i   (camt),
        .reg_amt_i     (ramt),
        .use_reg_amt_i (usereg),
        .mode_i        (mode),
        .result_o      (res)
    );

    // Behavioural model by bit index.
    function automatic logic [31:0] model(input logic [31:0] s, input logic [4:0] c,
                                          input logic [31:0] r, input logic u,
                                          input logic [2:0] m);
        logic [31:0] o;
        int n;
        n = u ? int'(r % 32) : int'(c);
        o = '0;
        for (int i = 0; i < 32; i++) begin
            case (m)
                3'd0: o[i] = (i >= n) ? s[i-n] : 1'b0;
                3'd1: o[i] = (i + n < 32) ? s[i+n] : 1'b0;
                3'd2: o[i] = (i + n < 32) ? s[i+n] : s[31];
                3'd3: o[i] = s[(i+n)%32];
                3'd4: o[i] = s[(i-n+32)%32];
                default: o[i] = 1'b0;
            endcase
        end
        return o;
    endfunction

    task automatic check(input string tag, input logic [31:0] exp);
        checks++;
        if (res !== exp) begin
            fails++;
            $display("FAIL %s mode=%0d actual=%h expected=%h", tag, mode, res, exp);
        end
    endtask

    // Apply one vector at a falling edge and compare one cycle later.
    task automatic run(input string tag, input logic [31:0] s, input logic [4:0] c,
                       input logic [31:0] r, input logic u, input logic [2:0] m);
        logic [31:0] exp;
        @(negedge clk);
        src = s; camt = c; ramt = r; usereg = u; mode = m;
        exp = model(s, c, r, u, m);
        @(negedge clk);
        check(tag, exp);
    endtask

    function automatic logic [31:0] step(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; src = 32'hFFFF_FFFF; camt = 5'd3; ramt = '0; usereg = 1'b0; mode = 3'd1;
        repeat (3) @(negedge clk);
        check("R9 reset", 32'h0);
        rst_n = 1'b1;

        run("R1 sll by 6",          32'h0000_AB29, 5'd6,  0, 1'b0, 3'd0);
        run("R1 sll loses top",     32'hFFFF_FFFF, 5'd31, 0, 1'b0, 3'd0);
        run("R2 srl by 4",          32'hF000_0000, 5'd4,  0, 1'b0, 3'd1);
        run("R2 srl neg by 31",     32'h8000_0000, 5'd31, 0, 1'b0, 3'd1);
        run("R3 sra neg by 31",     32'h8000_0000, 5'd31, 0, 1'b0, 3'd2);
        run("R3 sra pos by 5",      32'h7000_0000, 5'd5,  0, 1'b0, 3'd2);
        run("R4 ror by 8",          32'h1234_5678, 5'd8,  0, 1'b0, 3'd3);
        run("R5 rol by 1",          32'h8000_0001, 5'd1,  0, 1'b0, 3'd4);
        run("R5 rol by 31",         32'h0000_0001, 5'd31, 0, 1'b0, 3'd4);
        run("R6 reg amt upper ign", 32'hDEAD_BEEF, 5'd0,  32'hFFFF_FFE3, 1'b1, 3'd3);
        run("R6 const ignores reg", 32'hDEAD_BEEF, 5'd2,  32'h0000_0011, 1'b0, 3'd1);
        run("R6 R7 rol reg low 0",  32'hCAFE_F00D, 5'd7,  32'hFFFF_FFE0, 1'b1, 3'd4);
        for (int m = 0; m < 5; m++)
            run("R7 zero amount",   32'hA5C3_0F96, 5'd0,  0, 1'b0, 3'(m));
        for (int m = 5; m < 8; m++)
            run("R10 bad mode",     32'hFFFF_FFFF, 5'd3,  0, 1'b0, 3'(m));
        for (int a = 0; a < 32; a++)
            for (int m = 0; m < 5; m++)
                run("R8 every const",   32'h9E37_79B9, 5'(a), 0, 1'b0, 3'(m));

        @(negedge clk);
        src = 32'h1; camt = 5'd0; mode = 3'd0; usereg = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid reset", 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            lfsr = step(lfsr); a = lfsr;
            lfsr = step(lfsr); b = lfsr;
            run("R1 R2 R3 R4 R5 R6 sweep", a, b[4:0], {b[31:8], b[7:0] ^ a[7:0]},
                b[5], 3'(b[8 +: 3] % 6));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule